// File: doc/BRIEF.md
# Processor Event Counter Bank

This block holds eight 32-bit event counters for a small processor core. Each counter has its own mode word, which picks the pipeline event strobes it adds up and the privilege levels it counts in. The core reaches the bank through its special-purpose register port. A counter whose mode selects several events adds at most one per cycle, so one counter can, for example, tally every memory access by enabling both the load and the store event.

Software finds each counter through a read-only presence bit in its mode word. It clears a counter by writing zero to it, and stops one by writing zero to its mode word. The event strobes come from the pipeline and the watchpoint unit, and each is a single-cycle pulse.

Top module: `perf_event_bank`

## Requirements
- R1: Count register n (0..7) sits at address (7 << 11) + n and mode register n at (7 << 11) + 8 + n; a write to either is read back from the same address on the next cycle.
- R2: Mode bit 0 always reads 1 and ignores writes; bit 1 and bits 26..31 always read 0; bits 2..25 read back what was written.
- R3: Mode bit 2 permits counting while sup_mode_i is 1, and mode bit 3 permits counting while sup_mode_i is 0; a counter without the bit for the current privilege does not change.
- R4: Mode bits 4..14 enable the named pipeline events on evt_i[0..10] (4 load, 5 store, 6 fetch, 7 data cache miss, 8 instruction cache miss, 9 fetch stall, 10 load/store stall, 11 branch stall, 12 data TLB miss, 13 instruction TLB miss, 14 dependency stall); mode bits 15..25 enable the watchpoint events on evt_i[11..21]. Mode bit k thus gates evt_i[k-4].
- R5: A counter goes up by exactly 1 in a cycle in which at least one enabled strobe is high and the privilege is permitted, however many enabled strobes are high.
- R6: A counter at 0xFFFFFFFF that increments reads 0 on the next cycle.
- R7: A write to a count register sets it to the written value even when an increment would apply in the same cycle.
- R8: Reads of any address outside the sixteen registers, including other groups and indices 16 and above in group 7, return 0, and writes there change no register.
- R9: After reset every count register reads 0 and every mode register reads 1.
- R10: After 0 is written to a mode register its counter stops on every event, and the mode register reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spr_addr | input | 16 | Special-purpose register address |
| spr_we | input | 1 | Write strobe for the addressed register |
| spr_wdata | input | 32 | Write data |
| spr_rdata | output | 32 | Combinational read data for spr_addr |
| evt_i | input | 22 | Single-cycle event strobes; bit j is enabled by mode bit j+4 |
| sup_mode_i | input | 1 | 1 while the core runs in supervisor mode |

## Verification
The assertions assume that the port addresses one register per cycle and that the strobes are plain per-cycle levels. A counter then sees at most one write per cycle and moves by no more than one step between writes. They also assume that nothing is written or strobed in the two cycles while reset is released. The stimulus holds the write strobe and events low until the internal reset is free. It then drives one address per cycle and draws privilege and strobe patterns freely, since any combination within a cycle is legal.

// File: rtl/perf_event_pkg.sv
package perf_event_pkg;
  localparam int unsigned SPR_W     = 32;
  localparam int unsigned MB_PRESENT = 0;
  localparam int unsigned MB_SUP    = 2;
  localparam int unsigned MB_USR    = 3;
  localparam int unsigned MB_EVT_LO = 4;
  localparam int unsigned EVT_NUM   = 22;
  localparam int unsigned MB_EVT_HI = MB_EVT_LO + EVT_NUM - 1;
  localparam logic [SPR_W-1:0] MODE_WMASK =
    ((SPR_W'(1) << (MB_EVT_HI + 1)) - 1) & ~(SPR_W'(1) << MB_PRESENT) & ~SPR_W'(2);
endpackage

// File: rtl/perf_spr_decode.sv
module perf_spr_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned GRP_SHIFT = 11,
  parameter int unsigned GROUP     = 7,
  parameter int unsigned NUM_CTR   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  output logic [NUM_CTR-1:0]  cnt_sel_o,
  output logic [NUM_CTR-1:0]  mode_sel_o,
  output logic [NUM_CTR-1:0]  cnt_we_o,
  output logic [NUM_CTR-1:0]  mode_we_o
);
  localparam int unsigned GRP_W = ADDR_W - GRP_SHIFT;
  localparam logic [GRP_W-1:0] GRP_ID = GRP_W'(GROUP);

  logic in_group;
  assign in_group = (addr_i[ADDR_W-1:GRP_SHIFT] == GRP_ID);

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_sel
    localparam logic [GRP_SHIFT-1:0] CNT_IDX  = GRP_SHIFT'(n);
    localparam logic [GRP_SHIFT-1:0] MODE_IDX = GRP_SHIFT'(NUM_CTR + n);
    assign cnt_sel_o[n]  = in_group && (addr_i[GRP_SHIFT-1:0] == CNT_IDX);
    assign mode_sel_o[n] = in_group && (addr_i[GRP_SHIFT-1:0] == MODE_IDX);
    assign cnt_we_o[n]   = we_i && cnt_sel_o[n];
    assign mode_we_o[n]  = we_i && mode_sel_o[n];
  end

  // R8
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cnt_we_o, mode_we_o}));
  // R8
  out_of_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_group |-> (cnt_sel_o == '0 && mode_sel_o == '0));
endmodule

// File: rtl/perf_mode_reg.sv
module perf_mode_reg
  import perf_event_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [SPR_W-1:0]   wdata_i,
  input  logic [EVT_NUM-1:0] evt_i,
  input  logic               sup_mode_i,
  output logic [SPR_W-1:0]   rd_o,
  output logic               inc_req_o
);
  logic [SPR_W-1:0] mode_q, mode_d;
  logic             priv_ok, evt_hit;

  always_comb begin
    mode_d = mode_q;
    if (we_i) mode_d = wdata_i & MODE_WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode_q <= '0;
    else if (we_i) mode_q <= mode_d;
  end

  assign priv_ok   = sup_mode_i ? mode_q[MB_SUP] : mode_q[MB_USR];
  assign evt_hit   = |(evt_i & mode_q[MB_EVT_HI:MB_EVT_LO]);
  assign inc_req_o = priv_ok && evt_hit;
  assign rd_o      = mode_q | (SPR_W'(1) << MB_PRESENT);

  // R3
  no_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[MB_SUP] && !mode_q[MB_USR]) |-> !inc_req_o);
  // R10
  cleared_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && wdata_i == '0) |=> (!inc_req_o && rd_o == SPR_W'(1)));
  // R2
  mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (rd_o[MB_PRESENT] && !rd_o[1] && rd_o[SPR_W-1:MB_EVT_HI+1] == '0
              && rd_o[MB_EVT_HI:MB_SUP] == $past(wdata_i[MB_EVT_HI:MB_SUP])));
endmodule

// File: rtl/perf_count_reg.sv
module perf_count_reg #(
  parameter int unsigned CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [CTR_W-1:0] wdata_i,
  input  logic             inc_i,
  output logic [CTR_W-1:0] cnt_o
);
  logic [CTR_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = we_i || inc_i;

  always_comb begin
    cnt_d = cnt_q;
    if (we_i)       cnt_d = wdata_i;
    else if (inc_i) cnt_d = cnt_q + CTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R7
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> cnt_o == $past(wdata_i));
  // R5
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i && inc_i) |=> cnt_o == $past(cnt_o) + CTR_W'(1));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i && !inc_i) |=> $stable(cnt_o));
  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i && inc_i && cnt_o == '1) |=> cnt_o == '0);
endmodule

// File: rtl/perf_event_bank.sv
module perf_event_bank
  import perf_event_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned GRP_SHIFT = 11,
  parameter int unsigned GROUP     = 7,
  parameter int unsigned NUM_CTR   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  spr_addr,
  input  logic               spr_we,
  input  logic [SPR_W-1:0]   spr_wdata,
  output logic [SPR_W-1:0]   spr_rdata,
  input  logic [EVT_NUM-1:0] evt_i,
  input  logic               sup_mode_i
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [NUM_CTR-1:0] cnt_sel, mode_sel, cnt_we, mode_we, inc_req;
  logic [SPR_W-1:0]   cnt_val  [NUM_CTR];
  logic [SPR_W-1:0]   mode_val [NUM_CTR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  perf_spr_decode #(
    .ADDR_W(ADDR_W), .GRP_SHIFT(GRP_SHIFT), .GROUP(GROUP), .NUM_CTR(NUM_CTR)
  ) dec_i (
    .clk(clk), .rst_n(rst_int_n), .addr_i(spr_addr), .we_i(spr_we),
    .cnt_sel_o(cnt_sel), .mode_sel_o(mode_sel),
    .cnt_we_o(cnt_we), .mode_we_o(mode_we)
  );

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
    perf_mode_reg mode_i (
      .clk(clk), .rst_n(rst_int_n), .we_i(mode_we[n]), .wdata_i(spr_wdata),
      .evt_i(evt_i), .sup_mode_i(sup_mode_i),
      .rd_o(mode_val[n]), .inc_req_o(inc_req[n])
    );
    perf_count_reg #(.CTR_W(SPR_W)) cnt_i (
      .clk(clk), .rst_n(rst_int_n), .we_i(cnt_we[n]), .wdata_i(spr_wdata),
      .inc_i(inc_req[n]), .cnt_o(cnt_val[n])
    );
  end

  always_comb begin
    spr_rdata = '0;
    for (int n = 0; n < NUM_CTR; n++) begin
      if (cnt_sel[n])  spr_rdata = spr_rdata | cnt_val[n];
      if (mode_sel[n]) spr_rdata = spr_rdata | mode_val[n];
    end
  end

  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cnt_sel == '0 && mode_sel == '0) |-> spr_rdata == '0);
  // R9
  reset_state_chk: assert property (@(posedge clk)
    ($rose(rst_int_n) && mode_sel != '0) |-> spr_rdata == SPR_W'(1));
endmodule

// File: tb/perf_event_bank_tb.sv
module perf_event_bank_tb_top;
  localparam int unsigned AW = 16;
  localparam int unsigned NE = 22;
  localparam logic [15:0] BASE = 16'(7 << 11);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] spr_addr = '0;
  logic          spr_we = 1'b0;
  logic [31:0]   spr_wdata = '0;
  logic [31:0]   spr_rdata;
  logic [NE-1:0] evt = '0;
  logic          sup = 1'b0;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  logic [31:0] m_cnt [8];
  logic [31:0] m_mode[8];

  always #5 clk = ~clk;

  perf_event_bank dut_i (
    .clk(clk), .rst_n(rst_n), .spr_addr(spr_addr), .spr_we(spr_we),
    .spr_wdata(spr_wdata), .spr_rdata(spr_rdata), .evt_i(evt), .sup_mode_i(sup)
  );

  function automatic logic [31:0] model_read(logic [15:0] a);
    if (a[15:11] != 5'd7) return 32'h0;
    if (a[10:0] < 11'd8)  return m_cnt[a[2:0]];
    if (a[10:0] < 11'd16) return m_mode[a[2:0]] | 32'h1;
    return 32'h0;
  endfunction

  function automatic void model_clock(logic [15:0] a, logic we, logic [31:0] d,
                                      logic [NE-1:0] e, logic s);
    for (int n = 0; n < 8; n++) begin
      bit hit  = (e & m_mode[n][25:4]) != '0;
      bit priv = s ? m_mode[n][2] : m_mode[n][3];
      if (we && a == BASE + 16'(n))      m_cnt[n] = d;
      else if (hit && priv)              m_cnt[n] = m_cnt[n] + 32'd1;
    end
    for (int n = 0; n < 8; n++)
      if (we && a == BASE + 16'(8 + n)) m_mode[n] = d & 32'h03FF_FFFC;
  endfunction

  task automatic step(input logic [15:0] a, input logic we, input logic [31:0] d,
                      input logic [NE-1:0] e, input logic s, input string tag);
    logic [31:0] exp_v;
    @(negedge clk);
    spr_addr = a; spr_we = we; spr_wdata = d; evt = e; sup = s;
    #1;
    exp_v = model_read(a);
    n_vec++;
    if (spr_rdata !== exp_v) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, spr_rdata, exp_v);
    end
    @(posedge clk);
    model_clock(a, we, d, e, s);
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    step(a, 1'b0, 32'h0, '0, 1'b0, tag);
  endtask

  initial begin
    for (int n = 0; n < 8; n++) begin m_cnt[n] = '0; m_mode[n] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset values, R2 presence bit
    for (int n = 0; n < 16; n++) rd(BASE + 16'(n), "R9");

    // R2 mode write mask
    step(BASE + 16'd8, 1'b1, 32'hFFFF_FFFF, '0, 1'b0, "R2");
    rd(BASE + 16'd8, "R2");
    step(BASE + 16'd8, 1'b1, 32'h0, '0, 1'b0, "R10");
    rd(BASE + 16'd8, "R10");

    // R1 count write/readback
    step(BASE + 16'd1, 1'b1, 32'h0000_1234, '0, 1'b0, "R1");
    rd(BASE + 16'd1, "R1");

    // R3 privilege gate: mode2 = sup + data cache miss
    step(BASE + 16'd10, 1'b1, 32'h84, '0, 1'b0, "R3");
    step(BASE + 16'd2, 1'b0, 0, 22'h8, 1'b1, "R3");
    step(BASE + 16'd2, 1'b0, 0, 22'h8, 1'b0, "R3");
    rd(BASE + 16'd2, "R3");
    step(BASE + 16'd10, 1'b1, 32'h88, '0, 1'b0, "R3");
    step(BASE + 16'd2, 1'b0, 0, 22'h8, 1'b0, "R3");
    rd(BASE + 16'd2, "R3");

    // R5 load+store, both firing counts once
    step(BASE + 16'd8, 1'b1, 32'h34, '0, 1'b0, "R5");
    step(BASE + 16'd0, 1'b0, 0, 22'h3, 1'b1, "R5");
    step(BASE + 16'd0, 1'b0, 0, 22'h3FFFFF, 1'b1, "R5");
    rd(BASE + 16'd0, "R5");

    // R4 watchpoint bit 15 -> evt[11]; other events ignored
    step(BASE + 16'd12, 1'b1, 32'h8008, '0, 1'b0, "R4");
    step(BASE + 16'd4, 1'b0, 0, 22'h7FF, 1'b0, "R4");
    step(BASE + 16'd4, 1'b0, 0, 22'h800, 1'b0, "R4");
    rd(BASE + 16'd4, "R4");

    // R6 wrap
    step(BASE + 16'd3, 1'b1, 32'hFFFF_FFFF, '0, 1'b0, "R6");
    step(BASE + 16'd11, 1'b1, 32'h44, '0, 1'b0, "R6");
    step(BASE + 16'd3, 1'b0, 0, 22'h4, 1'b1, "R6");
    rd(BASE + 16'd3, "R6");

    // R7 write beats increment
    step(BASE + 16'd3, 1'b1, 32'h0000_0050, 22'h4, 1'b1, "R7");
    rd(BASE + 16'd3, "R7");

    // R8 unmapped writes and reads
    step(BASE + 16'd16, 1'b1, 32'hDEAD_BEEF, '0, 1'b0, "R8");
    step(16'(6 << 11) + 16'd3, 1'b1, 32'hDEAD_BEEF, '0, 1'b0, "R8");
    step(16'(5 << 11) + 16'd8, 1'b1, 32'hFFFF_FFFF, '0, 1'b0, "R8");
    for (int n = 0; n < 16; n++) rd(BASE + 16'(n), "R8");

    // R10 cleared mode stops counting
    step(BASE + 16'd11, 1'b1, 32'h0, '0, 1'b0, "R10");
    step(BASE + 16'd3, 1'b0, 0, 22'h3FFFFF, 1'b1, "R10");
    rd(BASE + 16'd3, "R10");
    rd(BASE + 16'd11, "R10");

    // mixed traffic checked against the model every cycle (R1 R3 R4 R5 R7 R8)
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic        we;
      logic [31:0] d;
      int unsigned k = $urandom_range(0, 19);
      if (k < 17) a = BASE + 16'($urandom_range(0, 17));
      else        a = 16'($urandom_range(0, 65535));
      we = ($urandom_range(0, 9) < 2);
      d  = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFF0 + 32'($urandom_range(0, 15))
                                       : $urandom;
      step(a, we, d, NE'($urandom) & NE'($urandom), 1'($urandom), "RND");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule